// File: doc/BRIEF.md
# NAND Bad Block Scanner

This block walks a range of erase blocks on a NAND flash device and records, for each block, whether it carries a factory bad-block marker. For every block in the range it requests the first page of that block from a page-read engine, consumes six spare-area bytes from the response stream, judges the marker according to the device's bus width and page size, and writes one flag through a write port into an internal table of per-block flags. Each table entry carries a known bit that is cleared by reset, so a block that has never been scanned reads back as unknown rather than good.

A scan is launched by a one-cycle `scan_go` with signed first and last block numbers and the device geometry (block count, pages per block, large-page select, 16-bit bus select). The geometry is captured at launch. A first block outside the device is refused with a range error pulse. A negative last block, or one at or past the device end, means "up to the last block of the device". A failed page read aborts the scan with a read error pulse and leaves the failing block untouched.

The page-read request side is a valid/ready interface: `rd_req_valid` rises with a page number and both stay fixed until `rd_req_ready` is seen high at a clock edge. The response side is a byte stream, one spare byte per beat in index order 0 to 5. The scanner raises `rd_rsp_ready` only while it is collecting bytes, and a beat transfers only when `rd_rsp_valid` and `rd_rsp_ready` are both high. The supplier may hold `rd_rsp_valid` low for any number of cycles between beats. Control inputs and status outputs are plain signals.

Top module: `nand_bbt_scanner`

## Requirements
- R1: When `scan_go` is sampled while idle with `scan_first` negative or `scan_first` not below `dev_blocks`, `scan_range_err` pulses for one cycle on the next cycle, and no read request and no flag write follow.
- R2: A `scan_last` that is negative (for example -1), or that is not below `dev_blocks`, is replaced by `dev_blocks - 1`. A `scan_last` below `scan_first` leaves the range empty: `scan_done` pulses and no flag is written.
- R3: Blocks are visited in ascending order. For each block one read request is issued with page number block × `dev_ppb`, and exactly six response beats are consumed before that block's flag is written.
- R4: With `dev_wide_bus` = 1 a block is bad when spare byte 0 ANDed with spare byte 1 differs from 0xFF. This test is ORed with the page-size test of R5 or R6.
- R5: With `dev_big_page` = 0 (512-byte pages) a block is bad when spare byte 5 differs from 0xFF.
- R6: With `dev_big_page` = 1 (2048-byte pages) a block is bad when spare byte 0 differs from 0xFF. Spare bytes 2 to 4 never affect the result in any mode.
- R7: Each block produces exactly one single-cycle `flag_we` with `flag_blk` set to the block number and `flag_bad` set to 1 for bad and 0 for good. From the next cycle on, the query port shows `qry_known` = 1 and `qry_bad` equal to the written value for that block.
- R8: After reset every entry of the table reads `qry_known` = 0, and the block is idle with no request outstanding.
- R9: A response beat with `rd_rsp_err` = 1 ends the scan. `scan_read_err` pulses, `scan_done` does not pulse, and the current block's entry is not written. Earlier blocks of the scan keep their flags.
- R10: `scan_done` pulses for exactly one cycle, the cycle after the last block's flag write. At most one of `scan_done`, `scan_range_err` and `scan_read_err` is high in any cycle.
- R11: `rd_req_valid` and `rd_req_page` stay stable until accepted. `rd_req_valid` and `rd_rsp_ready` are never high together. Gaps in `rd_rsp_valid` stall the scan without changing its result.
- R12: A `scan_go` that arrives while `scan_busy` is high is ignored, and the running scan finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_go | input | 1 | One-cycle launch strobe |
| scan_first | input | CW+1 | Signed first block of the range |
| scan_last | input | CW+1 | Signed last block; negative or out of range means device end |
| dev_blocks | input | CW | Number of erase blocks in the device |
| dev_ppb | input | PPB_W | Pages per erase block |
| dev_big_page | input | 1 | 1 = 2048-byte pages, 0 = 512-byte pages |
| dev_wide_bus | input | 1 | 1 = 16-bit data bus |
| rd_req_valid | output | 1 | Page-read request valid |
| rd_req_ready | input | 1 | Page-read request accepted |
| rd_req_page | output | PAGE_W | Page number to read |
| rd_rsp_valid | input | 1 | Spare byte beat valid |
| rd_rsp_ready | output | 1 | Scanner collecting spare bytes |
| rd_rsp_byte | input | 8 | Spare byte, index order 0..5 |
| rd_rsp_err | input | 1 | Read failed (qualified by the beat) |
| flag_we | output | 1 | Flag write strobe |
| flag_blk | output | BW | Block number being written |
| flag_bad | output | 1 | 1 = bad, 0 = good |
| qry_blk | input | BW | Table query address |
| qry_known | output | 1 | Entry has been written since reset |
| qry_bad | output | 1 | Stored bad flag |
| scan_done | output | 1 | Scan finished pulse |
| scan_range_err | output | 1 | First block out of range pulse |
| scan_read_err | output | 1 | Scan aborted by read error pulse |
| scan_busy | output | 1 | Scan in progress |

(BW = clog2(MAX_BLOCKS), CW = BW+1.)

## Verification
The bench builds the scanner with MAX_BLOCKS = 16, PPB_W = 8 and PAGE_W = 16. With these values a full-device scan takes only a few hundred cycles, so every vector can check each block's flag through the query port. The 6-bit signed block inputs can carry both negative values and values past the device end, which makes range refusal and end clamping reachable. A pages-per-block value of 64 on a 16-block device still fits the 16-bit page number, so page stepping can be checked at the top of the range under all four width and page-size combinations.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int OOB_BYTES = 6;
  localparam int IDX_W     = $clog2(OOB_BYTES);

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_WR
  } scan_state_t;
endpackage

// File: rtl/nbs_range.sv
module nbs_range #(
  parameter int CW = 7,
  parameter int SW = CW + 1
) (
  input  logic [CW-1:0]        total,
  input  logic signed [SW-1:0] first_i,
  input  logic signed [SW-1:0] last_i,
  output logic                 ok,
  output logic                 empty,
  output logic [CW-1:0]        last_o
);
  logic signed [SW-1:0] total_s;
  logic                 clamp;

  always_comb begin
    total_s = $signed({1'b0, total});
    ok      = (first_i >= $signed(SW'(0))) && (first_i < total_s);
    clamp   = (last_i < $signed(SW'(0))) || (last_i >= total_s);
    last_o  = clamp ? (total - CW'(1)) : last_i[CW-1:0];
    empty   = !clamp && (last_i < first_i);
  end
endmodule

// File: rtl/nbs_spare_judge.sv
module nbs_spare_judge
  import nbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [7:0]       cap_byte,
  input  logic             wide_bus,
  input  logic             big_page,
  output logic             is_bad
);
  logic [7:0] spare [OOB_BYTES];

  for (genvar i = 0; i < OOB_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spare[i] <= 8'hFF;
      end else if (cap_en && (cap_idx == IDX_W'(i))) begin
        spare[i] <= cap_byte;
      end
    end
  end

  logic wide_hit, small_hit, large_hit;

  always_comb begin
    wide_hit  = wide_bus && ((spare[0] & spare[1]) != 8'hFF);
    small_hit = !big_page && (spare[5] != 8'hFF);
    large_hit = big_page && (spare[0] != 8'hFF);
    is_bad    = wide_hit || small_hit || large_hit;
  end
endmodule

// File: rtl/nbs_flag_table.sv
module nbs_flag_table #(
  parameter int NBLK = 64,
  parameter int AW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbad,
  input  logic [AW-1:0] raddr,
  output logic          rknown,
  output logic          rbad
);
  logic [NBLK-1:0] known_q;
  logic [NBLK-1:0] bad_q;

  for (genvar i = 0; i < NBLK; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        known_q[i] <= 1'b0;
        bad_q[i]   <= 1'b0;
      end else if (we && (waddr == AW'(i))) begin
        known_q[i] <= 1'b1;
        bad_q[i]   <= wbad;
      end
    end
  end

  always_comb begin
    rknown = known_q[raddr];
    rbad   = bad_q[raddr];
  end
endmodule

// File: rtl/nand_bbt_scanner.sv
module nand_bbt_scanner
  import nbs_pkg::*;
#(
  parameter int MAX_BLOCKS = 64,
  parameter int PPB_W      = 10,
  parameter int PAGE_W     = 24,
  localparam int BW        = $clog2(MAX_BLOCKS),
  localparam int CW        = BW + 1,
  localparam int SW        = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_go,
  input  logic signed [SW-1:0] scan_first,
  input  logic signed [SW-1:0] scan_last,
  input  logic [CW-1:0]        dev_blocks,
  input  logic [PPB_W-1:0]     dev_ppb,
  input  logic                 dev_big_page,
  input  logic                 dev_wide_bus,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [PAGE_W-1:0]    rd_req_page,
  input  logic                 rd_rsp_valid,
  output logic                 rd_rsp_ready,
  input  logic [7:0]           rd_rsp_byte,
  input  logic                 rd_rsp_err,
  output logic                 flag_we,
  output logic [BW-1:0]        flag_blk,
  output logic                 flag_bad,
  input  logic [BW-1:0]        qry_blk,
  output logic                 qry_known,
  output logic                 qry_bad,
  output logic                 scan_done,
  output logic                 scan_range_err,
  output logic                 scan_read_err,
  output logic                 scan_busy
);
  scan_state_t         state_q;
  logic [BW-1:0]       cur_q, last_q;
  logic [PAGE_W-1:0]   page_q;
  logic [PPB_W-1:0]    ppb_q;
  logic                big_q, wide_q;
  logic [IDX_W-1:0]    idx_q;
  logic                done_q, rerr_q, ferr_q;

  logic                rng_ok, rng_empty;
  logic [CW-1:0]       rng_last;
  logic                beat, judged_bad;

  nbs_range #(.CW(CW), .SW(SW)) u_range (
    .total   (dev_blocks),
    .first_i (scan_first),
    .last_i  (scan_last),
    .ok      (rng_ok),
    .empty   (rng_empty),
    .last_o  (rng_last)
  );

  assign beat = (state_q == S_RSP) && rd_rsp_valid;

  nbs_spare_judge u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (beat && !rd_rsp_err),
    .cap_idx  (idx_q),
    .cap_byte (rd_rsp_byte),
    .wide_bus (wide_q),
    .big_page (big_q),
    .is_bad   (judged_bad)
  );

  nbs_flag_table #(.NBLK(MAX_BLOCKS), .AW(BW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (flag_we),
    .waddr  (flag_blk),
    .wbad   (flag_bad),
    .raddr  (qry_blk),
    .rknown (qry_known),
    .rbad   (qry_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      page_q  <= '0;
      ppb_q   <= '0;
      big_q   <= 1'b0;
      wide_q  <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      rerr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rerr_q <= 1'b0;
      ferr_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (scan_go) begin
            if (!rng_ok) begin
              rerr_q <= 1'b1;
            end else if (rng_empty) begin
              done_q <= 1'b1;
            end else begin
              cur_q   <= scan_first[BW-1:0];
              last_q  <= rng_last[BW-1:0];
              page_q  <= PAGE_W'(scan_first[BW-1:0]) * PAGE_W'(dev_ppb);
              ppb_q   <= dev_ppb;
              big_q   <= dev_big_page;
              wide_q  <= dev_wide_bus;
              state_q <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (rd_req_ready) begin
            idx_q   <= '0;
            state_q <= S_RSP;
          end
        end
        S_RSP: begin
          if (beat) begin
            if (rd_rsp_err) begin
              ferr_q  <= 1'b1;
              state_q <= S_IDLE;
            end else if (idx_q == IDX_W'(OOB_BYTES - 1)) begin
              state_q <= S_WR;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        S_WR: begin
          if (cur_q == last_q) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cur_q   <= cur_q + BW'(1);
            page_q  <= page_q + PAGE_W'(ppb_q);
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_valid   = (state_q == S_REQ);
    rd_req_page    = page_q;
    rd_rsp_ready   = (state_q == S_RSP);
    flag_we        = (state_q == S_WR);
    flag_blk       = cur_q;
    flag_bad       = judged_bad;
    scan_done      = done_q;
    scan_range_err = rerr_q;
    scan_read_err  = ferr_q;
    scan_busy      = (state_q != S_IDLE);
  end
endmodule

// File: rtl/nbs_checks.sv
module nbs_checks #(
  parameter int BW     = 6,
  parameter int PAGE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [PAGE_W-1:0] rd_req_page,
  input logic              rd_rsp_ready,
  input logic              flag_we,
  input logic [BW-1:0]     flag_blk,
  input logic              flag_bad,
  input logic [BW-1:0]     qry_blk,
  input logic              qry_known,
  input logic              qry_bad,
  input logic              scan_done,
  input logic              scan_range_err,
  input logic              scan_read_err,
  input logic              scan_busy
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_page));

  p_req_rsp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_done, scan_range_err, scan_read_err}));

  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_range_err |-> !rd_req_valid && !flag_we && !scan_busy);

  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> !flag_we);

  p_table_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && (qry_blk == flag_blk) |=> qry_known && (qry_bad == $past(flag_bad)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_busy |-> !rd_req_valid && !rd_rsp_ready && !flag_we);

  p_err_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_read_err |-> !flag_we && !scan_busy);
endmodule

bind nand_bbt_scanner nbs_checks #(.BW(BW), .PAGE_W(PAGE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req_valid   (rd_req_valid),
  .rd_req_ready   (rd_req_ready),
  .rd_req_page    (rd_req_page),
  .rd_rsp_ready   (rd_rsp_ready),
  .flag_we        (flag_we),
  .flag_blk       (flag_blk),
  .flag_bad       (flag_bad),
  .qry_blk        (qry_blk),
  .qry_known      (qry_known),
  .qry_bad        (qry_bad),
  .scan_done      (scan_done),
  .scan_range_err (scan_range_err),
  .scan_read_err  (scan_read_err),
  .scan_busy      (scan_busy)
);

// File: tb/nand_bbt_scanner_tb_top.sv
`timescale 1ns/1ps
module nand_bbt_scanner_tb_top;
  localparam int MAXB   = 16;
  localparam int PPB_W  = 8;
  localparam int PAGE_W = 16;
  localparam int BW     = $clog2(MAXB);
  localparam int CW     = BW + 1;
  localparam int SW     = CW + 1;

  localparam int VN = 7;
  localparam int V_FIRST [VN] = '{0, 2, 3, 5, -2, 16, 7};
  localparam int V_LAST  [VN] = '{15, -1, 20, 5, 4, 3, 3};
  localparam int V_TOTAL [VN] = '{16, 16, 12, 16, 16, 16, 16};
  localparam int V_PPB   [VN] = '{4, 64, 32, 8, 4, 4, 4};
  localparam int V_BIG   [VN] = '{0, 1, 0, 1, 0, 0, 0};
  localparam int V_WIDE  [VN] = '{0, 0, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 scan_go = 1'b0;
  logic signed [SW-1:0] scan_first = '0;
  logic signed [SW-1:0] scan_last = '0;
  logic [CW-1:0]        dev_blocks = '0;
  logic [PPB_W-1:0]     dev_ppb = '0;
  logic                 dev_big_page = 1'b0;
  logic                 dev_wide_bus = 1'b0;
  logic                 rd_req_valid, rd_req_ready;
  logic [PAGE_W-1:0]    rd_req_page;
  logic                 rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
  logic [7:0]           rd_rsp_byte;
  logic                 flag_we, flag_bad;
  logic [BW-1:0]        flag_blk;
  logic [BW-1:0]        qry_blk = '0;
  logic                 qry_known, qry_bad;
  logic                 scan_done, scan_range_err, scan_read_err, scan_busy;

  nand_bbt_scanner #(.MAX_BLOCKS(MAXB), .PPB_W(PPB_W), .PAGE_W(PAGE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .scan_first(scan_first),
    .scan_last(scan_last), .dev_blocks(dev_blocks), .dev_ppb(dev_ppb),
    .dev_big_page(dev_big_page), .dev_wide_bus(dev_wide_bus),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_page(rd_req_page),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_byte(rd_rsp_byte),
    .rd_rsp_err(rd_rsp_err), .flag_we(flag_we), .flag_blk(flag_blk), .flag_bad(flag_bad),
    .qry_blk(qry_blk), .qry_known(qry_known), .qry_bad(qry_bad),
    .scan_done(scan_done), .scan_range_err(scan_range_err),
    .scan_read_err(scan_read_err), .scan_busy(scan_busy)
  );

  int total_checks = 0;
  int bad_checks = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total_checks++;
    if (!cond) begin
      bad_checks++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Spare content per block: pattern by block % 5.
  function automatic logic [7:0] spare_of(input int blk, input int idx);
    int kind = blk % 5;
    if (kind == 1 && idx == 0) return 8'h00;
    if (kind == 2 && idx == 5) return 8'h00;
    if (kind == 3 && idx == 1) return 8'h7F;
    if (kind == 4 && idx == 3) return 8'h00;
    return 8'hFF;
  endfunction

  // Marker rules R4/R5/R6
  function automatic bit exp_bad(input int blk, input int big, input int wide);
    logic [7:0] b0, b1, b5;
    b0 = spare_of(blk, 0);
    b1 = spare_of(blk, 1);
    b5 = spare_of(blk, 5);
    return ((wide != 0) && ((b0 & b1) != 8'hFF)) ||
           ((big == 0) && (b5 != 8'hFF)) ||
           ((big != 0) && (b0 != 8'hFF));
  endfunction

  // Bench-side expectations
  int cur_ppb = 1, cur_big = 0, cur_wide = 0;
  int exp_req_blk = 0, exp_wr_blk = 0, wr_cnt = 0, done_cnt = 0;
  int err_page = -1;
  bit gap_en = 1'b0;

  // Page read model
  logic req_fire_q = 1'b0, rsp_fire_q = 1'b0;
  always @(posedge clk) begin
    req_fire_q <= rd_req_valid && rd_req_ready;
    rsp_fire_q <= rd_rsp_valid && rd_rsp_ready;
  end

  int  m_page = 0, m_idx = 0;
  bit  m_send = 1'b0, m_tog = 1'b0;
  initial begin
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_byte  = 8'hFF;
    rd_rsp_err   = 1'b0;
  end

  always @(negedge clk) begin
    m_tog = ~m_tog;
    if (!rst_n) begin
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
      rd_rsp_err   = 1'b0;
      m_send = 1'b0;
    end else begin
      if (m_send && rsp_fire_q) begin
        if (rd_rsp_err) m_send = 1'b0;
        m_idx++;
        if (m_idx == 6) m_send = 1'b0;
      end
      if (req_fire_q) begin
        rd_req_ready = 1'b0;
        m_send = 1'b1;
        m_idx = 0;
      end else if (rd_req_valid && !rd_req_ready && !m_send) begin
        rd_req_ready = 1'b1;
        m_page = int'(rd_req_page);
        chk(rd_req_page == PAGE_W'(exp_req_blk * cur_ppb), "R3 request page", int'(rd_req_page),
            exp_req_blk * cur_ppb);
        exp_req_blk++;
      end
      rd_rsp_valid = m_send && !(gap_en && m_tog);
      rd_rsp_byte  = spare_of(m_page / cur_ppb, m_idx);
      rd_rsp_err   = m_send && (m_page == err_page) && (m_idx == 2);
    end
  end

  // Write and done monitor
  always @(negedge clk) begin
    if (rst_n && flag_we) begin
      chk(int'(flag_blk) == exp_wr_blk, "R7 write order", int'(flag_blk), exp_wr_blk);
      chk(flag_bad == exp_bad(exp_wr_blk, cur_big, cur_wide), "R4/R5/R6 flag value",
          int'(flag_bad), int'(exp_bad(exp_wr_blk, cur_big, cur_wide)));
      exp_wr_blk++;
      wr_cnt++;
    end
    if (rst_n && scan_done) done_cnt++;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // 0 = done, 1 = range error, 2 = read error, 3 = timeout
  task automatic run_scan(input int first, input int last, input int total, input int ppb,
                          input int big, input int wide, input int busy_poke, output int kind);
    cur_ppb = ppb; cur_big = big; cur_wide = wide;
    exp_req_blk = first; exp_wr_blk = first; wr_cnt = 0; done_cnt = 0;
    @(negedge clk);
    scan_first   = SW'(first);
    scan_last    = SW'(last);
    dev_blocks   = CW'(total);
    dev_ppb      = PPB_W'(ppb);
    dev_big_page = big[0];
    dev_wide_bus = wide[0];
    scan_go      = 1'b1;
    @(negedge clk);
    scan_go = 1'b0;
    kind = 3;
    for (int c = 0; c < 20000; c++) begin
      if (busy_poke != 0 && c == 20) begin
        scan_first = SW'(9);
        scan_go = 1'b1;
      end else begin
        scan_go = 1'b0;
      end
      if (scan_done)      begin kind = 0; break; end
      if (scan_range_err) begin kind = 1; break; end
      if (scan_read_err)  begin kind = 2; break; end
      @(negedge clk);
    end
    scan_go = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad_checks++;
    total_checks++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin : main
    int kind, lastc, nexp;
    bit ok;
    do_reset();

    // R8: reset state
    begin
      int unknown = 0;
      for (int b = 0; b < MAXB; b++) begin
        qry_blk = BW'(b);
        #1;
        if (!qry_known) unknown++;
      end
      chk(unknown == MAXB, "R8 table unknown after reset", unknown, MAXB);
      chk(!scan_busy && !rd_req_valid, "R8 idle after reset", int'(scan_busy), 0);
    end

    // Vector table
    for (int v = 0; v < VN; v++) begin
      gap_en = v[0];
      ok = (V_FIRST[v] >= 0) && (V_FIRST[v] < V_TOTAL[v]);
      lastc = (V_LAST[v] < 0 || V_LAST[v] >= V_TOTAL[v]) ? V_TOTAL[v] - 1 : V_LAST[v];
      nexp = (!ok || lastc < V_FIRST[v]) ? 0 : lastc - V_FIRST[v] + 1;
      run_scan(V_FIRST[v], V_LAST[v], V_TOTAL[v], V_PPB[v], V_BIG[v], V_WIDE[v], 0, kind);
      chk(kind == (ok ? 0 : 1), ok ? "R10 done pulse" : "R1 range refusal", kind, ok ? 0 : 1);
      chk(wr_cnt == nexp, "R2 written block count", wr_cnt, nexp);
      chk(done_cnt == (ok ? 1 : 0), "R10 single done", done_cnt, ok ? 1 : 0);
      if (ok) begin
        int wrong = 0;
        for (int b = V_FIRST[v]; b <= lastc; b++) begin
          qry_blk = BW'(b);
          #1;
          if (!qry_known || qry_bad != exp_bad(b, V_BIG[v], V_WIDE[v])) wrong++;
        end
        chk(wrong == 0, "R7 query after scan", wrong, 0);
      end
    end

    // R12: start while busy is ignored
    gap_en = 1'b1;
    run_scan(0, 15, 16, 4, 0, 0, 1, kind);
    chk(kind == 0 && wr_cnt == 16, "R12 busy start ignored", wr_cnt, 16);
    chk(done_cnt == 1, "R12 one done", done_cnt, 1);

    // R9: read error aborts, failing block stays unknown
    do_reset();
    err_page = 12;
    run_scan(0, 7, 16, 4, 0, 0, 0, kind);
    chk(kind == 2, "R9 read error pulse", kind, 2);
    chk(wr_cnt == 3 && done_cnt == 0, "R9 writes before abort", wr_cnt, 3);
    qry_blk = BW'(3);
    #1;
    chk(!qry_known, "R9 failing block untouched", int'(qry_known), 0);
    qry_blk = BW'(2);
    #1;
    chk(qry_known && qry_bad == exp_bad(2, 0, 0), "R9 earlier block kept", int'(qry_known), 1);
    err_page = -1;

    // R11: scanner recovers after abort, gaps tolerated, 16-bit small page
    gap_en = 1'b1;
    run_scan(3, 3, 16, 4, 0, 1, 0, kind);
    chk(kind == 0 && wr_cnt == 1, "R11 recover after abort", wr_cnt, 1);

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule